// File: doc/BRIEF.md
# Dot-Matrix Row Scan and Drive-Level Generator

This block drives the row scan of a dot-matrix liquid crystal panel at a duty of one row in `NROWS`. It divides the oscillator clock down to a line clock. On every shift edge of that line clock it advances a scan position, steps a line address through the bitmap RAM and latches that line's segment bits. When the scan position wraps, a frame begins: the line address is reloaded from a start-line input, which scrolls the picture vertically with no copying in RAM. The frame AC polarity flips at the same point.

The bitmap RAM is organised in pages of eight lines. The block presents a page number and receives one byte per column for that page. It then picks the bit of each byte that matches the line inside the page. Every common output and every segment output is encoded as a 3-bit drive-level code. The code depends on row selection, pixel data, AC polarity and the display-enable input. The analog level generation and the host access path lie outside the block.

Top module: `lcd_row_scan`

## Requirements
- R1: While `rst_n` is low, and after its release until the first shift event: the scan position is 0, the line address is 0, `ac_pol` is 0, `line_clk` is 0 and the latched segment row is all zeros. With `scan_down`=0, common 0 therefore shows code 5 and every other common shows code 1. With `disp_on`=1 every segment shows code 2.
- R2: `line_clk` has a period of `DIV_HI` oscillator cycles when `fs_hi`=1 and `DIV_LO` cycles when `fs_hi`=0. It is low for the first half of each period and high for the second half.
- R3: A shift event occurs at the rising edge of `line_clk` when `phase_fall`=0 and at its falling edge when `phase_fall`=1. All scan state updates in the same oscillator cycle as that edge.
- R4: Each shift event advances the scan position by one. The line address steps up by one modulo `NROWS`.
- R5: When the scan position wraps from `NROWS`-1 to 0, the line address is loaded from `start_line` and `ac_pol` toggles.
- R6: Common number `pos` is selected when `scan_down`=0, and common `NROWS-1-pos` is selected when `scan_down`=1. Exactly one common is selected at any time.
- R7: `ram_page` carries the upper bits of the line address that the next shift event will latch (address divided by 8). The bit latched for column c is bit (address mod 8) of `ram_bytes[c*8 +: 8]`.
- R8: With `col_rev`=0, segment j takes column j. With `col_rev`=1, segment j takes column `NSEG-1-j`. The setting applies when the row is latched.
- R9: Common codes: a selected common shows 5 when `ac_pol`=0 and 0 when `ac_pol`=1. An unselected common shows 1 when `ac_pol`=0 and 4 when `ac_pol`=1.
- R10: Segment codes: a latched 1 shows 0 when `ac_pol`=0 and 5 when `ac_pol`=1. A latched 0 shows 2 or 3 under the same polarities. When `disp_on`=0, every segment shows 2 or 3 by polarity, whatever the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_hi | input | 1 | Selects the divisor: 1 gives DIV_HI, 0 gives DIV_LO |
| scan_down | input | 1 | Reverses the order of common selection |
| phase_fall | input | 1 | Scan advances on the falling edge of line_clk when 1 |
| col_rev | input | 1 | Maps RAM columns to segments in reverse order |
| disp_on | input | 1 | Enables pixel data on the segments |
| start_line | input | LW | Line address loaded at the start of each frame |
| ram_bytes | input | NSEG*8 | One byte per column for the addressed page |
| ram_page | output | LW-3 | Page of the line to be latched next |
| line_clk | output | 1 | Divided line clock |
| ac_pol | output | 1 | Frame AC polarity |
| com_lvl | output | NROWS*3 | Drive-level code for each common |
| seg_lvl | output | NSEG*3 | Drive-level code for each segment |

## Verification
The bench builds the block with 16 rows, 4 segments and divisors of 8 and 4. A full frame then takes only 16 line events, so the start-line reload and the polarity flip recur many times in a short run. Two pages are present, so page selection and the in-page bit position are both exercised. With four segments, a column reversal shows as a clearly different pattern, and the short divisors let the line clock's period and duty be measured exactly in oscillator cycles.

// File: rtl/lcd_scan_pkg.sv
`timescale 1ns/1ps
package lcd_scan_pkg;

  typedef logic [2:0] lvl_t;

  localparam lvl_t LVL_V0 = 3'd0;
  localparam lvl_t LVL_V1 = 3'd1;
  localparam lvl_t LVL_V2 = 3'd2;
  localparam lvl_t LVL_V3 = 3'd3;
  localparam lvl_t LVL_V4 = 3'd4;
  localparam lvl_t LVL_V5 = 3'd5;

  // next value of a counter that wraps after n-1
  function automatic int step_wrap(input int v, input int n);
    return (v + 1 >= n) ? 0 : v + 1;
  endfunction

  // level code of one common line
  function automatic lvl_t com_code(input logic sel, input logic ac);
    if (sel) return ac ? LVL_V0 : LVL_V5;
    return ac ? LVL_V4 : LVL_V1;
  endfunction

  // level code of one segment line
  function automatic lvl_t seg_code(input logic dat, input logic ac, input logic on);
    if (on && dat) return ac ? LVL_V5 : LVL_V0;
    return ac ? LVL_V3 : LVL_V2;
  endfunction

endpackage

// File: rtl/scan_divider.sv
`timescale 1ns/1ps
module scan_divider #(
  parameter int DIV_HI = 96,
  parameter int DIV_LO = 48,
  localparam int CW = $clog2(DIV_HI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_hi,
  output logic line_clk,
  output logic rise_evt,
  output logic fall_evt
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] div;
  logic [CW-1:0] half;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    div      = fs_hi ? CW'(DIV_HI) : CW'(DIV_LO);
    half     = div >> 1;
    rise_evt = (cnt == half - CW'(1));
    fall_evt = (cnt >= div - CW'(1));
    cnt_nxt  = fall_evt ? '0 : cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      line_clk <= 1'b0;
    end else begin
      cnt      <= cnt_nxt;
      line_clk <= (cnt_nxt >= half);
    end
  end

endmodule

// File: rtl/scan_sequencer.sv
`timescale 1ns/1ps
module scan_sequencer
  import lcd_scan_pkg::*;
#(
  parameter int NROWS = 64,
  localparam int LW = $clog2(NROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_evt,
  input  logic [LW-1:0] start_line,
  output logic [LW-1:0] pos,
  output logic [LW-1:0] line_addr,
  output logic [LW-1:0] nxt_addr,
  output logic          frame_wrap,
  output logic          ac_pol
);

  logic [LW-1:0] nxt_pos;

  always_comb begin
    frame_wrap = (int'(pos) == NROWS - 1);
    nxt_pos    = LW'(step_wrap(int'(pos), NROWS));
    nxt_addr   = frame_wrap ? start_line : LW'(step_wrap(int'(line_addr), NROWS));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      line_addr <= '0;
      ac_pol    <= 1'b0;
    end else if (shift_evt) begin
      pos       <= nxt_pos;
      line_addr <= nxt_addr;
      if (frame_wrap) ac_pol <= ~ac_pol;
    end
  end

endmodule

// File: rtl/row_latch.sv
`timescale 1ns/1ps
module row_latch #(
  parameter int NSEG = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            col_rev,
  input  logic [2:0]      bit_sel,
  input  logic [NSEG*8-1:0] ram_bytes,
  output logic [NSEG-1:0] row_bits
);

  logic [NSEG-1:0] fwd_bits;
  logic [NSEG-1:0] rev_bits;

  for (genvar j = 0; j < NSEG; j++) begin : g_col
    localparam int RJ = NSEG - 1 - j;
    logic [7:0] fwd_byte;
    logic [7:0] rev_byte;
    assign fwd_byte    = ram_bytes[j*8 +: 8];
    assign rev_byte    = ram_bytes[RJ*8 +: 8];
    assign fwd_bits[j] = fwd_byte[bit_sel];
    assign rev_bits[j] = rev_byte[bit_sel];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    row_bits <= '0;
    else if (load) row_bits <= col_rev ? rev_bits : fwd_bits;
  end

endmodule

// File: rtl/level_encoder.sv
`timescale 1ns/1ps
module level_encoder
  import lcd_scan_pkg::*;
#(
  parameter int NROWS = 64,
  parameter int NSEG  = 128
) (
  input  logic [NROWS-1:0]   com_sel,
  input  logic [NSEG-1:0]    row_bits,
  input  logic               ac_pol,
  input  logic               disp_on,
  output logic [NROWS*3-1:0] com_lvl,
  output logic [NSEG*3-1:0]  seg_lvl
);

  for (genvar i = 0; i < NROWS; i++) begin : g_com
    assign com_lvl[i*3 +: 3] = com_code(com_sel[i], ac_pol);
  end

  for (genvar j = 0; j < NSEG; j++) begin : g_seg
    assign seg_lvl[j*3 +: 3] = seg_code(row_bits[j], ac_pol, disp_on);
  end

endmodule

// File: rtl/lcd_row_scan.sv
`timescale 1ns/1ps
module lcd_row_scan #(
  parameter int NROWS  = 64,
  parameter int NSEG   = 128,
  parameter int DIV_HI = 96,
  parameter int DIV_LO = 48,
  localparam int LW = $clog2(NROWS),
  localparam int PW = LW - 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fs_hi,
  input  logic               scan_down,
  input  logic               phase_fall,
  input  logic               col_rev,
  input  logic               disp_on,
  input  logic [LW-1:0]      start_line,
  input  logic [NSEG*8-1:0]  ram_bytes,
  output logic [PW-1:0]      ram_page,
  output logic               line_clk,
  output logic               ac_pol,
  output logic [NROWS*3-1:0] com_lvl,
  output logic [NSEG*3-1:0]  seg_lvl
);

  logic            rise_evt;
  logic            fall_evt;
  logic            shift_evt;
  logic            frame_wrap;
  logic [LW-1:0]   pos;
  logic [LW-1:0]   line_addr;
  logic [LW-1:0]   nxt_addr;
  logic [LW-1:0]   sel_idx;
  logic [NROWS-1:0] com_sel;
  logic [NSEG-1:0] row_bits;

  scan_divider #(.DIV_HI(DIV_HI), .DIV_LO(DIV_LO)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fs_hi    (fs_hi),
    .line_clk (line_clk),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  assign shift_evt = phase_fall ? fall_evt : rise_evt;

  scan_sequencer #(.NROWS(NROWS)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_evt  (shift_evt),
    .start_line (start_line),
    .pos        (pos),
    .line_addr  (line_addr),
    .nxt_addr   (nxt_addr),
    .frame_wrap (frame_wrap),
    .ac_pol     (ac_pol)
  );

  assign ram_page = nxt_addr[LW-1:3];

  row_latch #(.NSEG(NSEG)) lat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (shift_evt),
    .col_rev   (col_rev),
    .bit_sel   (nxt_addr[2:0]),
    .ram_bytes (ram_bytes),
    .row_bits  (row_bits)
  );

  assign sel_idx = scan_down ? LW'(NROWS - 1) - pos : pos;

  for (genvar i = 0; i < NROWS; i++) begin : g_sel
    assign com_sel[i] = (sel_idx == LW'(i));
  end

  level_encoder #(.NROWS(NROWS), .NSEG(NSEG)) enc_i (
    .com_sel  (com_sel),
    .row_bits (row_bits),
    .ac_pol   (ac_pol),
    .disp_on  (disp_on),
    .com_lvl  (com_lvl),
    .seg_lvl  (seg_lvl)
  );

endmodule

// File: rtl/lcd_row_scan_chk.sv
`timescale 1ns/1ps
module lcd_row_scan_chk #(
  parameter int NROWS = 64,
  localparam int LW = $clog2(NROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_evt,
  input logic             line_clk,
  input logic             ac_pol,
  input logic [LW-1:0]    pos,
  input logic [LW-1:0]    line_addr,
  input logic [LW-1:0]    start_line,
  input logic [NROWS-1:0] com_sel
);

  AST_EVT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> line_clk != $past(line_clk)); // R3

  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_evt |=> $stable(pos) && $stable(line_addr)); // R4

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt && int'(pos) != NROWS - 1 && int'(line_addr) != NROWS - 1
      |=> line_addr == $past(line_addr) + LW'(1)); // R4

  AST_LOAD_START: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt && int'(pos) == NROWS - 1 |=> line_addr == $past(start_line) && pos == '0); // R5

  AST_AC_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt && int'(pos) == NROWS - 1 |=> ac_pol != $past(ac_pol)); // R5

  AST_AC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !(shift_evt && int'(pos) == NROWS - 1) |=> $stable(ac_pol)); // R5

  AST_ONE_COM: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(com_sel) == 1); // R6

endmodule

bind lcd_row_scan lcd_row_scan_chk #(.NROWS(NROWS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_evt  (shift_evt),
  .line_clk   (line_clk),
  .ac_pol     (ac_pol),
  .pos        (pos),
  .line_addr  (line_addr),
  .start_line (start_line),
  .com_sel    (com_sel)
);

// File: tb/lcd_row_scan_tb_top.sv
`timescale 1ns/1ps
module lcd_row_scan_tb_top;

  localparam int NR = 16;
  localparam int NS = 4;
  localparam int DH = 8;
  localparam int DL = 4;
  localparam int LW = $clog2(NR);
  localparam int PW = LW - 3;

  // {fs_hi, scan_down, phase_fall, col_rev, disp_on, start_line[3:0], events[7:0]}
  localparam logic [16:0] VEC [0:5] = '{
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5,  8'd20},
    {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd9,  8'd18},
    {1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 4'd15, 8'd20},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd3,  8'd17},
    {1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0,  8'd34},
    {1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd12, 8'd20}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_hi = 1'b1, scan_down = 1'b0, phase_fall = 1'b0, col_rev = 1'b0, disp_on = 1'b1;
  logic [LW-1:0] start_line = '0;
  logic [NS*8-1:0] ram_bytes;
  logic [PW-1:0] ram_page;
  logic line_clk, ac_pol;
  logic [NR*3-1:0] com_lvl;
  logic [NS*3-1:0] seg_lvl;

  int checks = 0;
  int errors = 0;
  int m_pos, m_addr, m_ac;
  int m_row [NS];

  always #2 clk = ~clk;

  lcd_row_scan #(.NROWS(NR), .NSEG(NS), .DIV_HI(DH), .DIV_LO(DL)) dut_i (
    .clk(clk), .rst_n(rst_n), .fs_hi(fs_hi), .scan_down(scan_down),
    .phase_fall(phase_fall), .col_rev(col_rev), .disp_on(disp_on),
    .start_line(start_line), .ram_bytes(ram_bytes), .ram_page(ram_page),
    .line_clk(line_clk), .ac_pol(ac_pol), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
  );

  function automatic logic [7:0] mem_byte(input int page, input int col);
    return 8'((page * 53 + col * 29 + 7) ^ (col << page));
  endfunction

  always_comb begin
    for (int c = 0; c < NS; c++) ram_bytes[c*8 +: 8] = mem_byte(int'(ram_page), c);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // compare all outputs against the bench model
  task automatic compare_all();
    int sel;
    sel = scan_down ? NR - 1 - m_pos : m_pos;
    check("R5 ac_pol", int'(ac_pol), m_ac);
    for (int i = 0; i < NR; i++) begin
      int e;
      if (i == sel) e = m_ac ? 0 : 5;
      else          e = m_ac ? 4 : 1;
      check((i == sel) ? "R6/R9 selected com" : "R9 unselected com", int'(com_lvl[i*3 +: 3]), e);
    end
    for (int j = 0; j < NS; j++) begin
      int e;
      if (disp_on && m_row[j] == 1) e = m_ac ? 5 : 0;
      else                          e = m_ac ? 3 : 2;
      check("R7/R8/R10 seg", int'(seg_lvl[j*3 +: 3]), e);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    m_pos = 0; m_addr = 0; m_ac = 0;
    for (int j = 0; j < NS; j++) m_row[j] = 0;
    check("R1 line_clk in reset", int'(line_clk), 0);
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 line_clk after release", int'(line_clk), 0);
  endtask

  task automatic one_event();
    if (phase_fall) @(negedge line_clk);
    else            @(posedge line_clk);
    @(negedge clk);
    if (m_pos == NR - 1) begin
      m_pos  = 0;
      m_addr = int'(start_line);
      m_ac   = 1 - m_ac;
    end else begin
      m_pos  = m_pos + 1;
      m_addr = (m_addr + 1) % NR;
    end
    for (int j = 0; j < NS; j++) begin
      int col;
      col = col_rev ? NS - 1 - j : j;
      m_row[j] = int'(mem_byte(m_addr / 8, col)[m_addr % 8]);
    end
    compare_all();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    @(negedge clk);
    do_reset();

    // table walk: each entry starts from reset (R3 R4 R5 R6 R7 R8 R9 R10)
    for (int v = 0; v < 6; v++) begin
      {fs_hi, scan_down, phase_fall, col_rev, disp_on} = VEC[v][16:12];
      start_line = VEC[v][11:8];
      do_reset();
      for (int k = 0; k < int'(VEC[v][7:0]); k++) one_event();
    end

    // R10: disabling the display blanks segments at once, enabling restores data
    disp_on = 1'b0;
    #1;
    compare_all();
    disp_on = 1'b1;
    #1;
    compare_all();

    // R2: line clock period and duty for each divisor
    for (int f = 0; f < 2; f++) begin
      realtime t_r1, t_f, t_r2;
      fs_hi = f[0];
      do_reset();
      @(posedge line_clk); t_r1 = $realtime;
      @(negedge line_clk); t_f  = $realtime;
      @(posedge line_clk); t_r2 = $realtime;
      check("R2 period", int'((t_r2 - t_r1) / 4.0), f ? DH : DL);
      check("R2 high time", int'((t_f - t_r1) / 4.0), (f ? DH : DL) / 2);
    end

    // R3: event edge follows phase selection (falling phase, one event)
    fs_hi = 1'b1; phase_fall = 1'b1; scan_down = 1'b0;
    do_reset();
    @(posedge line_clk);
    @(negedge clk);
    check("R3 no advance on rising edge in falling phase",
          int'(com_lvl[0 +: 3]), 5);
    one_event();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule